// File: doc/BRIEF.md
# Segment Load Access Checker

This block decides whether a protected-mode segment register load may go ahead. A request carries the target kind (code or data), the 16-bit selector, the descriptor fields that were already read and decoded (system flag, 4-bit type, present bit, privilege level), the current privilege level, and a flag that says whether the selector lies outside its descriptor table. The block answers with one verdict for each request. The verdict is either a pass or a fault. A fault comes in one of two classes: general protection or not-present. Each verdict carries a reason code and a selector value. On a fault that value is the original selector, used as the error value. On a pass it is the selector to load. The block does not read descriptors and does not write segment registers.

Requests come in and verdicts go out over valid/ready handshakes. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its verdict appears on the next cycle and stays on the response port until `rsp_ready` is high. While a verdict waits, `req_ready` is low, so back-pressure reaches the requester within the same cycle. When the response port drains, a new request can be accepted in that same cycle, so the block sustains one verdict per clock.

Top module: `seg_load_checker`

## Requirements
- R1: If the selector is not a null selector on a data load and `req_out_of_table` is 1, the verdict is general protection (`rsp_fault`=1) with reason 1 on a code load or reason 5 on a data load. No type, privilege or presence check applies.
- R2: A code load of a conforming code descriptor (`req_sys`=0, type bit 3 = 1, bit 2 = 1, readable or not) faults with general protection, reason 3, when the descriptor level is above the current level. A selector RPL above the current level is allowed.
- R3: A code load of a non-conforming code descriptor (type bit 3 = 1, bit 2 = 0) faults with general protection, reason 3, when the selector RPL (bits 1:0) is above the current level or the descriptor level differs from it.
- R4: A code load of any descriptor that is not code faults with general protection, reason 2. This covers a system descriptor (`req_sys`=1) and any type with bit 3 = 0.
- R5: A data load accepts readable code (type bit 3 = 1 with bit 1 = 1) and all four data types (bit 3 = 0; bit 2 = expand-down, bit 1 = writeable). Type bit 0 is ignored. A system descriptor or non-readable code faults with general protection, reason 6.
- R6: A data load of any accepted type other than conforming readable code requires current level <= descriptor level and RPL <= descriptor level. Otherwise it faults with general protection, reason 7. Conforming readable code skips this rule.
- R7: A clear present bit gives a not-present fault (`rsp_fault`=2), with reason 4 on a code load or reason 8 on a data load. This happens only when the table, type and privilege checks all passed; otherwise the earlier general-protection verdict is reported.
- R8: On a data load, a null selector passes with reason 0 whatever the other inputs are. A null selector has bits 15:2 all zero, and its RPL bits are ignored. On a code load a null selector gets no such exemption.
- R9: A passing code load returns the selector with bits 1:0 replaced by the current level. A passing data load returns the selector unchanged. A fault returns the original selector. Reason 0 appears only on a pass (`rsp_fault`=0).
- R10: Each accepted request yields exactly one verdict, one cycle later. While `rsp_valid` is high and `rsp_ready` is low, the verdict holds steady and `req_ready` is low.
- R11: After reset `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge if valid |
| req_is_data | input | 1 | 0 = code load, 1 = data load |
| req_sel | input | 16 | Selector; bits 1:0 are the RPL |
| req_sys | input | 1 | Descriptor is a system descriptor |
| req_type | input | 4 | Descriptor type field |
| req_present | input | 1 | Descriptor present bit |
| req_dpl | input | 2 | Descriptor privilege level |
| req_cpl | input | 2 | Current privilege level |
| req_out_of_table | input | 1 | Selector lies beyond the table limit |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_fault | output | 2 | 0 pass, 1 general protection, 2 not-present |
| rsp_reason | output | 4 | Reason code, 0 on a pass |
| rsp_sel | output | 16 | Selector to load, or error value |

## Verification
The hardest verdicts to reach are those where several checks fail at once. Only the first failing check in the order must show. Examples are a missing descriptor that also breaks the privilege rule, an out-of-table selector carrying a bad type, and a null data selector with every other input set to fail. The vector table builds each of these by setting two or more failing conditions together. A directed test stalls the response port while a second request waits, then releases it, so that acceptance and drain happen in the same cycle.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GP     = 2'd1,
    FLT_ABSENT = 2'd2
  } fault_e;

  typedef enum logic [3:0] {
    RSN_NONE     = 4'd0,
    RSN_C_SEL    = 4'd1,
    RSN_C_TYPE   = 4'd2,
    RSN_C_PRIV   = 4'd3,
    RSN_C_ABSENT = 4'd4,
    RSN_D_SEL    = 4'd5,
    RSN_D_TYPE   = 4'd6,
    RSN_D_PRIV   = 4'd7,
    RSN_D_ABSENT = 4'd8
  } reason_e;

  // check stage that failed, in evaluation order
  typedef enum logic [2:0] {
    STP_PASS   = 3'd0,
    STP_SEL    = 3'd1,
    STP_TYPE   = 3'd2,
    STP_PRIV   = 3'd3,
    STP_ABSENT = 3'd4
  } step_e;

  localparam int unsigned DATA_RSN_OFS = 4;

endpackage

// File: rtl/seg_type_class.sv
module seg_type_class (
  input  logic       sys,
  input  logic [3:0] typ,
  output logic       is_code,
  output logic       is_conf,
  output logic       is_read,
  output logic       is_seg
);
  // bit 3: code; for code bit 2 conforming, bit 1 readable
  always_comb begin
    is_seg  = !sys;
    is_code = !sys && typ[3];
    is_conf = !sys && typ[3] && typ[2];
    is_read = !sys && (!typ[3] || typ[1]);
  end
endmodule

// File: rtl/seg_rule_eval.sv
module seg_rule_eval
  import seg_chk_pkg::*;
#(
  parameter int unsigned SEL_W = 16,
  parameter int unsigned PL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_data,
  input  logic [SEL_W-1:0] sel,
  input  logic             sys,
  input  logic [3:0]       typ,
  input  logic             present,
  input  logic [PL_W-1:0]  dpl,
  input  logic [PL_W-1:0]  cpl,
  input  logic             oot,
  output fault_e           fault,
  output reason_e          reason,
  output logic [SEL_W-1:0] sel_out
);
  localparam int unsigned IDX_W = SEL_W - PL_W;

  logic            c_code, c_conf, c_read, c_seg;
  logic [PL_W-1:0] rpl;
  logic            null_sel, type_ok, priv_ok;
  step_e           step;

  seg_type_class u_cls (
    .sys    (sys),
    .typ    (typ),
    .is_code(c_code),
    .is_conf(c_conf),
    .is_read(c_read),
    .is_seg (c_seg)
  );

  assign rpl      = sel[PL_W-1:0];
  assign null_sel = (sel[SEL_W-1:PL_W] == '0);

  always_comb begin
    if (is_data) begin
      type_ok = c_seg && c_read;
      priv_ok = (c_code && c_conf) || ((cpl <= dpl) && (rpl <= dpl));
    end else begin
      type_ok = c_code;
      priv_ok = c_conf ? (dpl <= cpl) : ((rpl <= cpl) && (dpl == cpl));
    end
  end

  always_comb begin
    if (is_data && null_sel) step = STP_PASS;
    else if (oot)            step = STP_SEL;
    else if (!type_ok)       step = STP_TYPE;
    else if (!priv_ok)       step = STP_PRIV;
    else if (!present)       step = STP_ABSENT;
    else                     step = STP_PASS;
  end

  always_comb begin
    unique case (step)
      STP_PASS:   fault = FLT_NONE;
      STP_ABSENT: fault = FLT_ABSENT;
      default:    fault = FLT_GP;
    endcase
    if (step == STP_PASS) reason = RSN_NONE;
    else reason = reason_e'({1'b0, step} + (is_data ? 4'(DATA_RSN_OFS) : 4'd0));
    if (!is_data && step == STP_PASS) sel_out = {sel[SEL_W-1:PL_W], cpl};
    else                              sel_out = sel;
  end

  // R1
  oot_gp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oot && !(is_data && null_sel)) |-> (fault == FLT_GP && (reason == RSN_C_SEL || reason == RSN_D_SEL)));
  // R7
  absent_only_if_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault == FLT_ABSENT) |-> !present);
  // R8
  null_data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_data && sel[SEL_W-1:PL_W] == IDX_W'(0)) |-> (fault == FLT_NONE && sel_out == sel));
  // R9
  code_rpl_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_data && fault == FLT_NONE) |-> (sel_out[PL_W-1:0] == cpl));
  // R9
  reason_pairs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reason == RSN_NONE) == (fault == FLT_NONE));
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int unsigned PAY_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R10
  accept_yields_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_chk_pkg::*;
#(
  parameter int unsigned SEL_W   = 16,
  parameter int unsigned PL_W    = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_is_data,
  input  logic [SEL_W-1:0] req_sel,
  input  logic             req_sys,
  input  logic [3:0]       req_type,
  input  logic             req_present,
  input  logic [PL_W-1:0]  req_dpl,
  input  logic [PL_W-1:0]  req_cpl,
  input  logic             req_out_of_table,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_fault,
  output logic [3:0]       rsp_reason,
  output logic [SEL_W-1:0] rsp_sel
);
  localparam int unsigned PAY_W = 2 + 4 + SEL_W;

  fault_e           ev_fault;
  reason_e          ev_reason;
  logic [SEL_W-1:0] ev_sel;
  logic [PAY_W-1:0] ev_pay, out_pay;

  seg_rule_eval #(.SEL_W(SEL_W), .PL_W(PL_W)) u_eval (
    .clk    (clk),
    .rst_n  (rst_n),
    .is_data(req_is_data),
    .sel    (req_sel),
    .sys    (req_sys),
    .typ    (req_type),
    .present(req_present),
    .dpl    (req_dpl),
    .cpl    (req_cpl),
    .oot    (req_out_of_table),
    .fault  (ev_fault),
    .reason (ev_reason),
    .sel_out(ev_sel)
  );

  assign ev_pay = {ev_fault, ev_reason, ev_sel};

  generate
    if (REG_OUT) begin : g_reg
      seg_rsp_reg #(.PAY_W(PAY_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_data  (ev_pay),
        .out_valid(rsp_valid),
        .out_ready(rsp_ready),
        .out_data (out_pay)
      );
    end else begin : g_comb
      assign req_ready = rsp_ready;
      assign rsp_valid = req_valid;
      assign out_pay   = ev_pay;
    end
  endgenerate

  assign rsp_fault  = out_pay[PAY_W-1 -: 2];
  assign rsp_reason = out_pay[SEL_W +: 4];
  assign rsp_sel    = out_pay[SEL_W-1:0];

  // R10
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/seg_load_checker_bench.sv
`timescale 1ns/1ps
module seg_load_checker_bench;
  typedef struct packed {
    logic [3:0]  rq;
    logic        dat;
    logic [15:0] sel;
    logic        sys;
    logic [3:0]  typ;
    logic        pres;
    logic [1:0]  dpl;
    logic [1:0]  cpl;
    logic        oot;
    logic [1:0]  ef;
    logic [3:0]  er;
    logic [15:0] es;
  } vec_t;

  function automatic vec_t mk(input logic [3:0] rq, input logic dat, input logic [15:0] sel,
                              input logic sys, input logic [3:0] typ, input logic pres,
                              input logic [1:0] dpl, input logic [1:0] cpl, input logic oot,
                              input logic [1:0] ef, input logic [3:0] er, input logic [15:0] es);
    return '{rq, dat, sel, sys, typ, pres, dpl, cpl, oot, ef, er, es};
  endfunction

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    mk(2, 0, 16'h0013, 0, 4'b1110, 1, 0, 2, 0, 0, 0, 16'h0012), // R2 R9 conforming, RPL above CPL ok
    mk(2, 0, 16'h0019, 0, 4'b1100, 1, 3, 1, 0, 1, 3, 16'h0019), // R2 DPL above CPL
    mk(3, 0, 16'h0020, 0, 4'b1010, 1, 1, 1, 0, 0, 0, 16'h0021), // R3 R9 pass, RPL stamped
    mk(3, 0, 16'h0022, 0, 4'b1010, 1, 1, 1, 0, 1, 3, 16'h0022), // R3 RPL above CPL
    mk(3, 0, 16'h0028, 0, 4'b1000, 1, 0, 1, 0, 1, 3, 16'h0028), // R3 DPL differs
    mk(4, 0, 16'h0030, 0, 4'b0010, 1, 0, 0, 0, 1, 2, 16'h0030), // R4 data type on code load
    mk(4, 0, 16'h0034, 1, 4'b1010, 1, 0, 0, 0, 1, 2, 16'h0034), // R4 system descriptor
    mk(1, 0, 16'h4000, 1, 4'b0000, 0, 3, 0, 1, 1, 1, 16'h4000), // R1 code, beyond table wins
    mk(7, 0, 16'h0048, 0, 4'b1010, 0, 0, 0, 0, 2, 4, 16'h0048), // R7 code absent
    mk(7, 0, 16'h004C, 0, 4'b1110, 0, 3, 0, 0, 1, 3, 16'h004C), // R7 privilege before presence
    mk(5, 1, 16'h0053, 0, 4'b0110, 1, 3, 3, 0, 0, 0, 16'h0053), // R5 R9 expand-down writeable
    mk(6, 1, 16'h0058, 0, 4'b0000, 1, 2, 3, 0, 1, 7, 16'h0058), // R6 CPL above DPL
    mk(6, 1, 16'h005B, 0, 4'b0000, 1, 2, 0, 0, 1, 7, 16'h005B), // R6 RPL above DPL
    mk(6, 1, 16'h0063, 0, 4'b1110, 1, 0, 3, 0, 0, 0, 16'h0063), // R6 conforming readable exempt
    mk(6, 1, 16'h0068, 0, 4'b1010, 1, 0, 3, 0, 1, 7, 16'h0068), // R6 non-conforming readable
    mk(5, 1, 16'h0070, 0, 4'b1000, 1, 3, 0, 0, 1, 6, 16'h0070), // R5 non-readable code
    mk(5, 1, 16'h0074, 1, 4'b0010, 1, 3, 0, 0, 1, 6, 16'h0074), // R5 system
    mk(1, 1, 16'h8004, 0, 4'b0010, 1, 3, 0, 1, 1, 5, 16'h8004), // R1 data beyond table
    mk(7, 1, 16'h0080, 0, 4'b0010, 0, 3, 0, 0, 2, 8, 16'h0080), // R7 data absent
    mk(8, 1, 16'h0003, 1, 4'b1000, 0, 0, 3, 1, 0, 0, 16'h0003), // R8 null data, all else bad
    mk(8, 0, 16'h0000, 0, 4'b1010, 1, 0, 0, 1, 1, 1, 16'h0000), // R8 null code not exempt
    mk(7, 1, 16'h0084, 0, 4'b0000, 0, 0, 3, 0, 1, 7, 16'h0084), // R7 data privilege first
    mk(5, 1, 16'h0090, 0, 4'b0011, 1, 3, 0, 0, 0, 0, 16'h0090)  // R5 accessed bit ignored
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_is_data = 0, req_sys = 0, req_present = 0, req_out_of_table = 0;
  logic rsp_ready = 1;
  logic [15:0] req_sel = '0;
  logic [3:0]  req_type = '0;
  logic [1:0]  req_dpl = '0, req_cpl = '0;
  logic req_ready, rsp_valid;
  logic [1:0]  rsp_fault;
  logic [3:0]  rsp_reason;
  logic [15:0] rsp_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seg_load_checker u_seg_load_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_sel(req_sel), .req_sys(req_sys), .req_type(req_type),
    .req_present(req_present), .req_dpl(req_dpl), .req_cpl(req_cpl),
    .req_out_of_table(req_out_of_table), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_reason(rsp_reason), .rsp_sel(rsp_sel)
  );

  task automatic drive(input vec_t v);
    req_is_data = v.dat; req_sel = v.sel; req_sys = v.sys; req_type = v.typ;
    req_present = v.pres; req_dpl = v.dpl; req_cpl = v.cpl; req_out_of_table = v.oot;
    req_valid = 1;
  endtask

  task automatic expect_rsp(input vec_t v, input string tag);
    checks++;
    if (!(rsp_valid && rsp_fault == v.ef && rsp_reason == v.er && rsp_sel == v.es)) begin
      errors++;
      $display("FAIL %s R%0d sel=%h: got v=%0d f=%0d r=%0d s=%h exp f=%0d r=%0d s=%h",
               tag, v.rq, v.sel, rsp_valid, rsp_fault, rsp_reason, rsp_sel, v.ef, v.er, v.es);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 got rsp_valid=%b req_ready=%b exp 0 1", rsp_valid, req_ready);
    end

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      req_valid = 0;
      expect_rsp(TBL[i], "vec");
      @(negedge clk);
    end

    // R10 back-pressure: hold first verdict, second request waits
    rsp_ready = 0;
    drive(TBL[0]);
    @(negedge clk);
    drive(TBL[3]);
    repeat (2) @(negedge clk);
    expect_rsp(TBL[0], "R10 hold");
    checks++;
    if (req_ready !== 1'b0) begin
      errors++;
      $display("FAIL R10 req_ready during stall got %b exp 0", req_ready);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    expect_rsp(TBL[3], "R10 next");
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10 extra verdict got rsp_valid=%b exp 0", rsp_valid);
    end

    // R10 back-to-back requests, one verdict per clock
    drive(TBL[10]);
    @(negedge clk);
    expect_rsp(TBL[10], "R10 b2b a");
    drive(TBL[17]);
    @(negedge clk);
    req_valid = 0;
    expect_rsp(TBL[17], "R10 b2b b");
    @(negedge clk);

    // R11 reset clears a pending verdict
    rsp_ready = 0;
    drive(TBL[5]);
    @(negedge clk);
    req_valid = 0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rsp_ready = 1;
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11 after reset got rsp_valid=%b req_ready=%b exp 0 1", rsp_valid, req_ready);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule